// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block turns two control inputs, a PWM signal and a direction signal, into four gate enables for a full H-bridge built from NMOS switches. The bridge has two legs. Each leg has a high-side and a low-side switch. The direction input picks one diagonal pair. The high-side switch of that pair stays on for the whole driving phase, and the PWM input chops only the low-side switch of the pair. The low-side switch of the other leg stays off, so the bridge does no synchronous rectification.

When the driven diagonal changes, or when the bridge starts up, every gate is held off for a programmable number of clock cycles before any new switch turns on. This dead time keeps the two switches of a leg from ever conducting together. An enable input (the active-mode condition) and a shutdown input both gate the whole bridge. When either calls for it, all four enables drop at the next clock edge, with no dead-time delay. The raw PWM and direction inputs pass through two-flop synchronizers before the sequencer uses them.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While reset is asserted, and after reset until the block is enabled, all four gate enables are 0.
- R2: With direction 1 the driven pair is high-side 1 and low-side 2. With direction 0 it is high-side 2 and low-side 1.
- R3: In the driving phase, the active low side follows the synchronized PWM input, and its output changes at the second clock edge after the PWM input changes. The active high side stays at 1 whatever the PWM level is, and the inactive leg's low side stays at 0.
- R4: When enable is 1 and shutdown is 0 at clock edge k, starting from the all-off state, all gates stay off until edge k+D+1 and the driven pair turns on at that edge. D is the dead-time setting.
- R5: A direction change seen at the input makes the old pair turn off at the third clock edge after the change. The new pair turns on D+1 cycles after that, and all gates are off in between.
- R6: With a dead-time setting of 0, a direction reversal still gives exactly one cycle with all gates off.
- R7: Shutdown at 1 on a clock edge turns all gates off at that edge and holds them off while it stays 1. After shutdown is released, the start-up sequence of R4 applies.
- R8: Enable at 0 on a clock edge turns all gates off at that edge. This is the sleep condition.
- R9: High side and low side of the same leg are never on together, and the two high sides are never on together.
- R10: The dead-time setting is an 8-bit cycle count, sampled when each dead phase begins. A setting of 255 gives 256 all-off cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwm_in | input | 1 | Raw PWM input that chops the active low side |
| dir_in | input | 1 | Raw direction input: 1 selects high-side 1 with low-side 2, 0 selects high-side 2 with low-side 1 |
| run_en | input | 1 | Active-mode enable; 0 forces every gate off |
| kill | input | 1 | Shutdown; 1 forces every gate off at the next edge |
| dead_cfg | input | 8 | Dead time in clock cycles (the all-off window is this value plus one) |
| gate_hs1 | output | 1 | Gate enable, high side of leg 1 |
| gate_hs2 | output | 1 | Gate enable, high side of leg 2 |
| gate_ls1 | output | 1 | Gate enable, low side of leg 1 |
| gate_ls2 | output | 1 | Gate enable, low side of leg 2 |

## Verification
The dead-window property compares the run of all-off cycles with the current dead-time setting, so it assumes the setting is not changed during a dead phase. The stimulus changes the setting only while the bridge is driving or is shut down. The shutdown and enable inputs are treated as synchronous to the clock, so the bench drives every input on the falling edge. Direction and PWM levels are held for several cycles, longer than the synchronizer depth, so that each change the bench expects actually reaches the sequencer.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_DEAD  = 2'd1,
    ST_DRIVE = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic hs1;
    logic hs2;
    logic ls1;
    logic ls2;
  } gate_set_t;

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign chain_d[s] = d;
      end else begin : g_rest
        assign chain_d[s] = chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/hbg_dead_timer.sv
module hbg_dead_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/hbg_fsm.sv
module hbg_fsm
  import hbg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      dir_s,
  input  logic      pwm_s,
  input  logic      timer_done,
  output logic      timer_load,
  output gate_set_t gates
);

  seq_state_e state_q, state_d;
  logic       dir_q, dir_d;
  logic       driving;

  always_comb begin
    state_d    = state_q;
    dir_d      = dir_q;
    timer_load = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        if (enable) begin
          state_d    = ST_DEAD;
          timer_load = 1'b1;
        end
      end
      ST_DEAD: begin
        if (!enable) begin
          state_d = ST_OFF;
        end else if (timer_done) begin
          state_d = ST_DRIVE;
          dir_d   = dir_s;
        end
      end
      ST_DRIVE: begin
        if (!enable) begin
          state_d = ST_OFF;
        end else if (dir_s != dir_q) begin
          state_d    = ST_DEAD;
          timer_load = 1'b1;
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
    end
  end

  always_comb begin
    driving   = (state_q == ST_DRIVE);
    gates.hs1 = driving &&  dir_q;
    gates.ls2 = driving &&  dir_q && pwm_s;
    gates.hs2 = driving && !dir_q;
    gates.ls1 = driving && !dir_q && pwm_s;
  end

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hbg_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             dir_in,
  input  logic             run_en,
  input  logic             kill,
  input  logic [CNT_W-1:0] dead_cfg,
  output logic             gate_hs1,
  output logic             gate_hs2,
  output logic             gate_ls1,
  output logic             gate_ls2
);

  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] sync_q;
  logic              enable;
  logic              timer_load;
  logic              timer_done;
  gate_set_t         gates;

  hbg_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({dir_in, pwm_in}),
    .q     (sync_q)
  );

  assign enable = run_en && !kill;

  hbg_dead_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (dead_cfg),
    .done     (timer_done)
  );

  hbg_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .dir_s      (sync_q[1]),
    .pwm_s      (sync_q[0]),
    .timer_done (timer_done),
    .timer_load (timer_load),
    .gates      (gates)
  );

  assign gate_hs1 = gates.hs1;
  assign gate_hs2 = gates.hs2;
  assign gate_ls1 = gates.ls1;
  assign gate_ls2 = gates.ls2;

endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             kill,
  input logic [CNT_W-1:0] dead_cfg,
  input logic             gate_hs1,
  input logic             gate_hs2,
  input logic             gate_ls1,
  input logic             gate_ls2
);

  localparam int RUN_W = CNT_W + 1;

  logic             all_off;
  logic [RUN_W-1:0] off_run_q;

  assign all_off = !(gate_hs1 || gate_hs2 || gate_ls1 || gate_ls2);

  // Counts consecutive all-off cycles up to the previous cycle, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   off_run_q <= '0;
    else if (!all_off)            off_run_q <= '0;
    else if (off_run_q != '1)     off_run_q <= off_run_q + 1'b1;
  end

  assert_no_shoot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hs1 && gate_ls1) && !(gate_hs2 && gate_ls2) && !(gate_hs1 && gate_hs2));

  assert_low_pairs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_ls2 -> gate_hs1) && (gate_ls1 -> gate_hs2));

  assert_kill_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> all_off);

  assert_sleep_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> all_off);

  assert_gap_to_hs2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hs2) |-> !$past(gate_hs1));

  assert_gap_to_hs1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hs1) |-> !$past(gate_hs2));

  assert_dead_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hs1) || $rose(gate_hs2)) |-> (off_run_q > RUN_W'(dead_cfg)));

endmodule

bind hbridge_gate_seq hbg_checker #(.CNT_W(CNT_W)) u_hbg_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_en   (run_en),
  .kill     (kill),
  .dead_cfg (dead_cfg),
  .gate_hs1 (gate_hs1),
  .gate_hs2 (gate_hs2),
  .gate_ls1 (gate_ls1),
  .gate_ls2 (gate_ls2)
);

// File: tb/test_hbridge_gate_seq.sv
`timescale 1ns/1ps
module test_hbridge_gate_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwm_in, dir_in, run_en, kill;
  logic [7:0] dead_cfg;
  logic       gate_hs1, gate_hs2, gate_ls1, gate_ls2;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    int       due;
    logic [3:0] exp;
    string    tag;
  } item_t;

  item_t sb_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hbridge_gate_seq i_hbridge_gate_seq (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .dir_in(dir_in),
    .run_en(run_en), .kill(kill), .dead_cfg(dead_cfg),
    .gate_hs1(gate_hs1), .gate_hs2(gate_hs2),
    .gate_ls1(gate_ls1), .gate_ls2(gate_ls2)
  );

  // Gate vector order: {hs1, hs2, ls1, ls2}
  function automatic logic [3:0] drv(input logic d, input logic p);
    return d ? {1'b1, 1'b0, 1'b0, p} : {1'b0, 1'b1, p, 1'b0};
  endfunction

  localparam logic [3:0] OFF = 4'b0000;

  task automatic expect_at(input int due, input logic [3:0] exp, input string tag);
    item_t it;
    it.due = due; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic expect_off_range(input int from, input int upto, input string tag);
    for (int c = from; c <= upto; c++) expect_at(c, OFF, tag);
  endtask

  task automatic compare(input logic [3:0] act, input logic [3:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  // Monitor: pops scoreboard items as their cycle comes up.
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      compare({gate_hs1, gate_hs2, gate_ls1, gate_ls2}, sb_q[0].exp, sb_q[0].tag);
      void'(sb_q.pop_front());
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog cyc=%0d actual=hung expected=done", cyc);
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; pwm_in = 1'b0; dir_in = 1'b0; run_en = 1'b0; kill = 1'b0;
    dead_cfg = 8'd3;
    settle(3);
    compare({gate_hs1, gate_hs2, gate_ls1, gate_ls2}, OFF, "R1 in reset");
    rst_n = 1'b1;
    dir_in = 1'b1; pwm_in = 1'b1;
    n = cyc;
    expect_off_range(n + 1, n + 5, "R1 idle after reset");
    settle(6);

    // R4 start-up dead window, then R2 dir=1 pair
    n = cyc; run_en = 1'b1;
    expect_off_range(n, n + 3 + 1, "R4 start-up off");
    expect_at(n + 3 + 2, drv(1'b1, 1'b1), "R2 dir1 pair on");
    settle(10);

    // R3 PWM chops low side only
    n = cyc; pwm_in = 1'b0;
    expect_at(n + 1, drv(1'b1, 1'b1), "R3 pwm latency old");
    expect_at(n + 2, drv(1'b1, 1'b0), "R3 pwm low keeps hs1");
    settle(5);
    n = cyc; pwm_in = 1'b1;
    expect_at(n + 2, drv(1'b1, 1'b1), "R3 pwm high");
    settle(5);

    // R5 reversal with dead time 3
    n = cyc; dir_in = 1'b0;
    expect_at(n + 2, drv(1'b1, 1'b1), "R5 old pair still on");
    expect_off_range(n + 3, n + 3 + 3, "R5 reversal off");
    expect_at(n + 3 + 4, drv(1'b0, 1'b1), "R2 dir0 pair on");
    settle(12);
    n = cyc; pwm_in = 1'b0;
    expect_at(n + 2, drv(1'b0, 1'b0), "R3 dir0 pwm low keeps hs2");
    settle(5);

    // R6 reversal with dead time 0
    dead_cfg = 8'd0;
    settle(2);
    n = cyc; dir_in = 1'b1;
    expect_at(n + 2, drv(1'b0, 1'b0), "R6 old pair");
    expect_at(n + 3, OFF, "R6 single off cycle");
    expect_at(n + 4, drv(1'b1, 1'b0), "R6 new pair");
    settle(8);

    // R10 maximum dead time
    dead_cfg = 8'd255; pwm_in = 1'b1;
    settle(4);
    n = cyc; dir_in = 1'b0;
    expect_at(n + 3, OFF, "R10 window start");
    expect_at(n + 130, OFF, "R10 window mid");
    expect_at(n + 258, OFF, "R10 window end");
    expect_at(n + 259, drv(1'b0, 1'b1), "R10 pair after 256");
    settle(265);

    // R7 shutdown
    n = cyc; kill = 1'b1;
    expect_at(n, drv(1'b0, 1'b1), "R7 before kill");
    expect_at(n + 1, OFF, "R7 kill next cycle");
    settle(2);
    pwm_in = 1'b0;
    dead_cfg = 8'd2;
    expect_at(cyc + 4, OFF, "R7 held off");
    settle(6);
    n = cyc; kill = 1'b0;
    expect_off_range(n + 1, n + 3, "R7 restart dead");
    expect_at(n + 4, drv(1'b0, 1'b0), "R7 restart pair");
    settle(8);

    // R8 sleep
    pwm_in = 1'b1;
    settle(4);
    n = cyc; run_en = 1'b0;
    expect_at(n, drv(1'b0, 1'b1), "R8 before sleep");
    expect_at(n + 1, OFF, "R8 sleep off");
    expect_at(n + 5, OFF, "R8 sleep held");
    settle(8);
    n = cyc; run_en = 1'b1;
    expect_off_range(n, n + 3, "R4 wake off");
    expect_at(n + 4, drv(1'b0, 1'b1), "R4 wake pair");
    settle(8);

    while (sb_q.size() > 0) @(negedge clk);
    finish_run();
  end

endmodule